// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block turns one PWM command into two gate enables for a synchronous buck stage: a high-side enable for the upper switch and a low-side enable for the synchronous rectifier. It never lets both switches conduct together. In each direction it breaks one switch before it makes the other. When PWM falls, the high side is released at once. The low side then waits until an external comparator reports that the switch node has fallen low, or until a fixed timeout expires. When PWM rises, the low side is released at once. The high side then waits a programmable number of microsecond steps before it turns on.

Three inputs stop all switching: a run enable, an undervoltage flag and an over-temperature flag. Any of them forces both enables low in the same cycle. A separate low-side permit input keeps only the rectifier off, and the high side goes on following PWM. After reset, and after any of these stop conditions clears, the controller holds both enables low until it sees a fresh PWM edge. All inputs are expected to be already synchronous to `clk`. PWM, the enables and the flags are plain control levels, with no handshake.

Top module: `deadtime_gate_ctrl`

## Requirements
- R1: While `run_en_i` is 0, `hs_en_o` and `ls_en_o` are both 0 in that same cycle, whatever the other inputs are.
- R2: While `ls_allow_i` is 0, `ls_en_o` is 0. `hs_en_o` keeps its normal PWM timing.
- R3: PWM is high when `pwm_i` is 1. The first rising clock edge that samples `pwm_i` low after a high period clears `hs_en_o`. If `sw_low_i` is 1 (switch node low) at the next edge, `ls_en_o` is 1 after that edge.
- R4: If `sw_low_i` stays 0, `ls_en_o` goes to 1 after the SW_TIMEOUT-th edge that follows the edge that cleared `hs_en_o`. The default SW_TIMEOUT is 20.
- R5: `hs_dly_i` is a 7-bit unsigned count of 1 µs steps, and each step lasts CLK_MHZ clocks. `hs_en_o` goes to 1 after edge number 2 + `hs_dly_i`*CLK_MHZ, counting from the first edge that samples `pwm_i` high. A setting of 0 gives 2 edges.
- R6: While `uv_flag_i` is 1, both enables are 0 in that same cycle.
- R7: While `ot_flag_i` is 1, both enables are 0 in that same cycle.
- R8: `hs_en_o` and `ls_en_o` are never 1 in the same cycle. `hs_en_o` rises only when `ls_en_o` was 0 in the previous cycle.
- R9: If PWM reverses while a turn-on is still waiting, that turn-on never happens. The opposite sequence starts with its normal timing.
- R10: After reset, or after R1, R6 or R7 is released, both enables stay 0 until a PWM edge is seen. A level that is held unchanged drives neither enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM command, 1 = high side on |
| run_en_i | input | 1 | 1 = switching allowed |
| ls_allow_i | input | 1 | 0 = keep low-side enable off |
| sw_low_i | input | 1 | Comparator flag, 1 = switch node below threshold |
| uv_flag_i | input | 1 | Undervoltage flag, 1 = supply too low |
| ot_flag_i | input | 1 | Over-temperature flag, 1 = too hot |
| hs_dly_i | input | 7 | Extra high-side delay in µs steps |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
The hardest case to reach is a PWM reversal that arrives while a turn-on is still pending. It must come after the wait has begun but before it ends. The stimulus reaches it in two ways. It sets a 5 µs high-side delay and drops PWM 50 clocks into that wait. It also raises PWM again a few clocks into a low-side timeout wait, before the timeout can expire. In both cases the bench checks that the cancelled enable never appears and that the opposite enable arrives with its normal latency. A second difficult case is release from a fault while PWM is held at a steady level. The bench releases the fault without any PWM edge, checks that both enables stay low, and only then creates an edge.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HS_WAIT,
    ST_HS_ON,
    ST_LS_WAIT,
    ST_LS_ON
  } dt_state_e;
endpackage

// File: rtl/dt_us_tick.sv
module dt_us_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dt_down_cnt.sv
module dt_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (dec && !zero)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/deadtime_gate_ctrl.sv
module deadtime_gate_ctrl
  import dt_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int SW_TIMEOUT = 20,
  parameter int DLY_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_i,
  input  logic             run_en_i,
  input  logic             ls_allow_i,
  input  logic             sw_low_i,
  input  logic             uv_flag_i,
  input  logic             ot_flag_i,
  input  logic [DLY_W-1:0] hs_dly_i,
  output logic             hs_en_o,
  output logic             ls_en_o
);
  localparam int TO_W = $clog2(SW_TIMEOUT + 1);
  localparam logic [TO_W-1:0] TO_LOAD = TO_W'(SW_TIMEOUT - 1);

  dt_state_e st_q, st_d;
  logic pwm_q, seen_q;
  logic fault, rise, fall;
  logic hs_load, ls_load, us_tick, hs_zero, to_zero;

  assign fault = !run_en_i || uv_flag_i || ot_flag_i;
  assign rise  = seen_q && pwm_i && !pwm_q;
  assign fall  = seen_q && !pwm_i && pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q  <= 1'b0;
      seen_q <= 1'b0;
      st_q   <= ST_IDLE;
    end else begin
      pwm_q  <= pwm_i;
      seen_q <= 1'b1;
      st_q   <= st_d;
    end
  end

  always_comb begin
    st_d    = st_q;
    hs_load = 1'b0;
    ls_load = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (rise) begin
          st_d = ST_HS_WAIT; hs_load = 1'b1;
        end else if (fall) begin
          st_d = ST_LS_WAIT; ls_load = 1'b1;
        end
      end
      ST_HS_WAIT: begin
        if (!pwm_i) begin
          st_d = ST_LS_WAIT; ls_load = 1'b1;
        end else if (hs_zero) begin
          st_d = ST_HS_ON;
        end
      end
      ST_HS_ON: begin
        if (!pwm_i) begin
          st_d = ST_LS_WAIT; ls_load = 1'b1;
        end
      end
      ST_LS_WAIT: begin
        if (pwm_i) begin
          st_d = ST_HS_WAIT; hs_load = 1'b1;
        end else if (sw_low_i || to_zero) begin
          st_d = ST_LS_ON;
        end
      end
      ST_LS_ON: begin
        if (pwm_i) begin
          st_d = ST_HS_WAIT; hs_load = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (fault) begin
      st_d    = ST_IDLE;
      hs_load = 1'b0;
      ls_load = 1'b0;
    end
  end

  dt_us_tick #(.DIV(CLK_MHZ)) i_us_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hs_load),
    .tick  (us_tick)
  );

  dt_down_cnt #(.W(DLY_W)) i_hs_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hs_load),
    .load_val (hs_dly_i),
    .dec      ((st_q == ST_HS_WAIT) && us_tick),
    .zero     (hs_zero)
  );

  dt_down_cnt #(.W(TO_W)) i_to_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ls_load),
    .load_val (TO_LOAD),
    .dec      (st_q == ST_LS_WAIT),
    .zero     (to_zero)
  );

  assign hs_en_o = (st_q == ST_HS_ON) && !fault;
  assign ls_en_o = (st_q == ST_LS_ON) && ls_allow_i && !fault;
endmodule

// File: rtl/dt_checker.sv
module dt_checker (
  input logic clk,
  input logic rst_n,
  input logic pwm_i,
  input logic run_en_i,
  input logic ls_allow_i,
  input logic uv_flag_i,
  input logic ot_flag_i,
  input logic hs_en_o,
  input logic ls_en_o
);
  AST_RUN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en_i |-> (!hs_en_o && !ls_en_o)); // R1
  AST_LS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_allow_i |-> !ls_en_o); // R2
  AST_HS_NEEDS_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en_o |-> $past(pwm_i)); // R3
  AST_LS_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ls_en_o |-> !$past(pwm_i)); // R9
  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag_i |-> (!hs_en_o && !ls_en_o)); // R6
  AST_OT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag_i |-> (!hs_en_o && !ls_en_o)); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en_o && ls_en_o)); // R8
  AST_HS_AFTER_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en_o) |-> !$past(ls_en_o)); // R8
endmodule

bind deadtime_gate_ctrl dt_checker i_dt_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwm_i      (pwm_i),
  .run_en_i   (run_en_i),
  .ls_allow_i (ls_allow_i),
  .uv_flag_i  (uv_flag_i),
  .ot_flag_i  (ot_flag_i),
  .hs_en_o    (hs_en_o),
  .ls_en_o    (ls_en_o)
);

// File: tb/test_deadtime_gate_ctrl.sv
module test_deadtime_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CPU = 100;
  localparam int TO  = 20;
  localparam int NV  = 7;
  // fields: [8:2] delay setting, [1] comparator flag given, [0] low-side permit
  localparam logic [8:0] VEC [NV] = '{
    {7'd0,   1'b1, 1'b1},
    {7'd1,   1'b1, 1'b1},
    {7'd0,   1'b0, 1'b1},
    {7'd3,   1'b1, 1'b1},
    {7'd2,   1'b0, 1'b0},
    {7'd0,   1'b1, 1'b0},
    {7'd127, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b1, run_en = 1'b1, ls_allow = 1'b1, sw_low = 1'b0, uv = 1'b0, ot = 1'b0;
  logic [6:0] dly = '0;
  logic hs_en, ls_en;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  deadtime_gate_ctrl #(.CLK_MHZ(CPU), .SW_TIMEOUT(TO), .DLY_W(7)) i_deadtime_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .run_en_i(run_en), .ls_allow_i(ls_allow),
    .sw_low_i(sw_low), .uv_flag_i(uv), .ot_flag_i(ot), .hs_dly_i(dly),
    .hs_en_o(hs_en), .ls_en_o(ls_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_hs(input int start, output int n);
    n = start;
    do begin @(negedge clk); n++; end while (!hs_en && n < 20000);
  endtask

  task automatic wait_ls(input int start, output int n);
    n = start;
    do begin @(negedge clk); n++; end while (!ls_en && n < 20000);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // R8 overlap monitor on every cycle
  always @(negedge clk) if (rst_n && !done) check(!(hs_en && ls_en), "R8 overlap", 1, 0);

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    int n;
    tick_n(3);
    check(!hs_en && !ls_en, "R10 reset state", {hs_en, ls_en}, 0);
    rst_n = 1'b1;
    tick_n(10);
    check(!hs_en && !ls_en, "R10 held PWM after reset", {hs_en, ls_en}, 0);
    pwm = 1'b0; sw_low = 1'b1;
    wait_ls(0, n);
    check(n == 2, "R10 fall edge after reset", n, 2);
    sw_low = 1'b0;

    for (int v = 0; v < NV; v++) begin
      dly = VEC[v][8:2]; ls_allow = VEC[v][0];
      pwm = 1'b1;
      @(negedge clk);
      check(!ls_en && !hs_en, "R8 low side off first", {hs_en, ls_en}, 0);
      wait_hs(1, n);
      check(n == 2 + int'(dly) * CPU, "R5 high-side delay", n, 2 + int'(dly) * CPU);
      pwm = 1'b0; sw_low = VEC[v][1];
      @(negedge clk);
      check(!hs_en, "R3 high side released", hs_en, 0);
      if (VEC[v][0]) begin
        wait_ls(1, n);
        if (VEC[v][1]) check(n == 2, "R3 flag turn-on", n, 2);
        else           check(n == 1 + TO, "R4 timeout turn-on", n, 1 + TO);
      end else begin
        tick_n(TO + 3);
        check(!ls_en, "R2 low side blocked", ls_en, 0);
      end
      sw_low = 1'b0;
    end
    ls_allow = 1'b1;
    tick_n(2);

    // R1 shutdown, then release without an edge (R10)
    dly = 7'd0; pwm = 1'b1;
    wait_hs(0, n);
    check(n == 2, "R5 zero delay", n, 2);
    run_en = 1'b0; #1;
    check(!hs_en && !ls_en, "R1 shutdown immediate", {hs_en, ls_en}, 0);
    tick_n(5);
    check(!hs_en && !ls_en, "R1 shutdown held", {hs_en, ls_en}, 0);
    run_en = 1'b1;
    tick_n(10);
    check(!hs_en, "R10 no edge after shutdown", hs_en, 0);
    pwm = 1'b0; sw_low = 1'b1;
    wait_ls(0, n);
    check(n == 2, "R10 fall edge after shutdown", n, 2);
    sw_low = 1'b0;

    // R6 undervoltage during low-side on
    uv = 1'b1; #1;
    check(!ls_en && !hs_en, "R6 undervoltage off", {hs_en, ls_en}, 0);
    tick_n(3); uv = 1'b0;
    tick_n(10);
    check(!ls_en, "R10 no edge after undervoltage", ls_en, 0);
    pwm = 1'b1;
    wait_hs(0, n);
    check(n == 2, "R6 recovery on rise", n, 2);

    // R7 over-temperature during high-side on
    ot = 1'b1; #1;
    check(!hs_en && !ls_en, "R7 over-temperature off", {hs_en, ls_en}, 0);
    tick_n(2); ot = 1'b0;
    tick_n(10);
    check(!hs_en, "R10 no edge after over-temperature", hs_en, 0);
    pwm = 1'b0;
    wait_ls(0, n);
    check(n == 1 + TO, "R4 timeout after fault release", n, 1 + TO);

    // R9 cancel a pending high-side turn-on
    dly = 7'd5; pwm = 1'b1;
    tick_n(50);
    check(!hs_en && !ls_en, "R9 high side still waiting", {hs_en, ls_en}, 0);
    pwm = 1'b0; sw_low = 1'b1;
    wait_ls(0, n);
    check(n == 2, "R9 low side after cancel", n, 2);
    sw_low = 1'b0;
    tick_n(600);
    check(!hs_en && ls_en, "R9 cancelled high side never fires", {hs_en, ls_en}, 1);

    // R9 cancel a pending low-side turn-on
    dly = 7'd0; pwm = 1'b1;
    wait_hs(0, n);
    pwm = 1'b0;
    tick_n(5);
    check(!ls_en && !hs_en, "R9 low side still waiting", {hs_en, ls_en}, 0);
    pwm = 1'b1;
    wait_hs(0, n);
    check(n == 2, "R9 high side after cancel", n, 2);
    tick_n(TO + 5);
    check(hs_en && !ls_en, "R9 cancelled low side never fires", {hs_en, ls_en}, 2);

    summary();
  end
endmodule